// File: doc/BRIEF.md
# Block-Chained Receive Frame Buffer

This block sits between a serial HDLC receiver and a host. The receiver hands it one byte per cycle, and it stores the bytes in a 64-byte buffer made of eight 8-byte blocks. The last byte of a frame carries an end marker and a small status word. Every frame begins in a fresh block. A frame that ends therefore occupies whole blocks, and at most eight frames can wait in the buffer at once.

The host is served one unit at a time. A unit is either one complete frame or a 32-byte slice of a frame that is still arriving. A unit is latched into a presentation register and raises the interrupt. The interrupt stays up with a stable byte count, end flag and status until the host pulses acknowledge. The host reads the bytes of the unit in order with a read strobe. Acknowledge then frees the unit's blocks and lets the next unit through, so queued frames are handed over strictly one per interrupt.

When a byte arrives at a block boundary and every block is taken, the byte is dropped and the overflow flag is set. The rest of that frame is also dropped, and the frame is reported with its invalid bit set.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, irq, frame_cnt, frame_end, frame_stat and ovf are all 0.
- R2: A terminated frame of N bytes (N up to 64) raises irq with frame_cnt = N and frame_end = 1. frame_stat bits [2:0] hold the status given with the last byte, and bit 3 = 0. rd_data shows the frame's bytes in arrival order, and each cycle with rd_en high advances to the next byte.
- R3: Once 32 bytes of an unterminated frame are stored beyond what the host has already released, irq rises with frame_cnt = 32 and frame_end = 0. While such a slice is presented, frame_stat = 0.
- R4: A frame longer than 64 bytes is drained as successive 32-byte slices, followed by a final unit holding the remaining bytes with frame_end = 1.
- R5: Several complete frames can be queued. They are presented one at a time, in arrival order. Each presented unit holds its irq, frame_cnt and frame_end steady until host_ack.
- R6: Each frame starts in a fresh 8-byte block. With eight frames queued, a further frame finds no block: its bytes are dropped, ovf is set, and it never raises irq.
- R7: A byte that finds no free block sets ovf. The frame being received is then truncated to its stored bytes and presented with frame_stat bit 3 = 1. A host_ack clears ovf.
- R8: host_ack frees the blocks of the presented unit, so that a following 64 bytes of new frames are stored without overflow.
- R9: host_ack while irq is low has no effect: no data is released, and the next frame reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Received byte valid |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | Byte is the last of its frame (qualified by wr_en) |
| wr_stat | input | 3 | Frame status (CRC ok, abort, address match), taken with the last byte |
| rd_en | input | 1 | Host consumes the byte shown on rd_data |
| rd_data | output | 8 | Current byte of the presented unit |
| host_ack | input | 1 | Host releases the presented unit |
| irq | output | 1 | A unit is presented and waits for the host |
| frame_cnt | output | 7 | Byte count of the presented unit |
| frame_end | output | 1 | Presented unit closes its frame |
| frame_stat | output | 4 | Bit 3 invalid (overflow), bits 2:0 latched status |
| ovf | output | 1 | Sticky overflow flag, cleared by host_ack |

## Verification
The bench drives a single short frame, and then a burst of frames of unequal lengths queued before any service. These show whether the frame boundaries are kept and whether the frames come out in order. An 80-byte frame is split around a mid-frame service, which exercises both slice presentation and the final remainder. Eight one-byte frames followed by a ninth frame separate block-granular allocation from byte-exact allocation. A 66-byte frame written with no service in between hits overflow in the middle of the frame. The bench also sends an acknowledge with no unit presented, and then refills all blocks after draining, to confirm that release happens only on a real acknowledge.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned RFB_DW     = 8;
  localparam int unsigned RFB_STAT_W = 3;
  localparam int unsigned RFB_LEN_W  = 12;

  typedef struct packed {
    logic [RFB_LEN_W-1:0]  len;
    logic                  bad;
    logic [RFB_STAT_W-1:0] stat;
  } rfb_desc_t;
endpackage

// File: rtl/rfb_store.sv
module rfb_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [rfb_pkg::RFB_DW-1:0] wdata,
  input  logic [AW-1:0]              raddr,
  output logic [rfb_pkg::RFB_DW-1:0] rdata
);
  logic [rfb_pkg::RFB_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rfb_writer.sv
module rfb_writer
  import rfb_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned BLK_BYTES = 8,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned BOFF_W   = $clog2(BLK_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_last,
  input  logic [RFB_STAT_W-1:0] wr_stat,
  input  logic                  blk_full,
  output logic                  store,
  output logic [AW-1:0]         wr_addr,
  output logic                  alloc,
  output logic                  ovf_evt,
  output logic                  push,
  output rfb_desc_t             push_desc,
  output logic [RFB_LEN_W-1:0]  cur_len
);
  logic                  cur_bad, cur_bad_n;
  logic [AW-1:0]         wp_n, wp_inc;
  logic [RFB_LEN_W-1:0]  cur_len_n, len_inc;
  logic [AW-BOFF_W-1:0]  blk_up;
  logic                  at_edge;

  always_comb begin
    at_edge   = (wr_addr[BOFF_W-1:0] == '0);
    ovf_evt   = wr_en && !cur_bad && at_edge && blk_full;
    store     = wr_en && !cur_bad && !(at_edge && blk_full);
    alloc     = store && at_edge;
    len_inc   = cur_len + RFB_LEN_W'(store);
    push      = wr_en && wr_last && (len_inc != '0);
    push_desc = '{len: len_inc, bad: cur_bad | ovf_evt, stat: wr_stat};
    wp_inc    = wr_addr + AW'(store);
    blk_up    = wp_inc[AW-1:BOFF_W] + (AW-BOFF_W)'(|wp_inc[BOFF_W-1:0]);
    wp_n      = wp_inc;
    cur_len_n = cur_len;
    cur_bad_n = cur_bad;
    if (wr_en) begin
      cur_len_n = len_inc;
      cur_bad_n = cur_bad | ovf_evt;
      if (wr_last) begin
        wp_n      = {blk_up, {BOFF_W{1'b0}}};
        cur_len_n = '0;
        cur_bad_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      cur_len <= '0;
      cur_bad <= 1'b0;
    end else if (wr_en) begin
      wr_addr <= wp_n;
      cur_len <= cur_len_n;
      cur_bad <= cur_bad_n;
    end
  end

  // R6
  fresh_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_last) |=> (wr_addr[BOFF_W-1:0] == '0));
endmodule

// File: rtl/rfb_desc_q.sv
module rfb_desc_q
  import rfb_pkg::*;
#(
  parameter int unsigned QD = 9,
  localparam int unsigned PW = $clog2(QD),
  localparam int unsigned CW = $clog2(QD + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rfb_desc_t push_desc,
  input  logic      pop,
  output rfb_desc_t head,
  output logic      empty,
  output logic      full
);
  rfb_desc_t      slot [QD];
  logic [PW-1:0]  wp, rp, wp_n, rp_n;
  logic [CW-1:0]  cnt, cnt_n;

  always_comb begin
    wp_n  = push ? ((wp == PW'(QD - 1)) ? '0 : wp + 1'b1) : wp;
    rp_n  = pop  ? ((rp == PW'(QD - 1)) ? '0 : rp + 1'b1) : rp;
    cnt_n = cnt + CW'(push) - CW'(pop);
    empty = (cnt == '0);
    full  = (cnt == CW'(QD));
    head  = slot[rp];
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= push_desc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (push || pop) begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  // R5
  q_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5
  q_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rfb_pkg::*;
#(
  parameter int unsigned BLK_BYTES  = 8,
  parameter int unsigned NUM_BLKS   = 8,
  parameter int unsigned CHUNK_BLKS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [RFB_DW-1:0]                         wr_data,
  input  logic                                      wr_last,
  input  logic [RFB_STAT_W-1:0]                     wr_stat,
  input  logic                                      rd_en,
  output logic [RFB_DW-1:0]                         rd_data,
  input  logic                                      host_ack,
  output logic                                      irq,
  output logic [$clog2(BLK_BYTES*NUM_BLKS+1)-1:0]   frame_cnt,
  output logic                                      frame_end,
  output logic [RFB_STAT_W:0]                       frame_stat,
  output logic                                      ovf
);
  localparam int unsigned DEPTH  = BLK_BYTES * NUM_BLKS;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned BOFF_W = $clog2(BLK_BYTES);
  localparam int unsigned CHUNK  = CHUNK_BLKS * BLK_BYTES;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned BC_W   = $clog2(NUM_BLKS + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic                  store, alloc, ovf_evt, push, pop, q_empty, q_full;
  logic [AW-1:0]         wr_addr, rp, rp_n, rd_off, rd_off_n;
  logic [RFB_LEN_W-1:0]  cur_len, hd_off, hd_off_n, unit_size, unit_blks;
  rfb_desc_t             push_desc, head;
  logic [BC_W-1:0]       blk_used, blk_used_n, pres_blks;
  logic                  unit_rdy, unit_done, load, rel, ovf_n;
  logic [RFB_STAT_W:0]   unit_stat;

  rfb_writer #(.DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES)) u_writer (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_last(wr_last), .wr_stat(wr_stat),
    .blk_full(blk_used == BC_W'(NUM_BLKS)), .store(store), .wr_addr(wr_addr),
    .alloc(alloc), .ovf_evt(ovf_evt), .push(push), .push_desc(push_desc),
    .cur_len(cur_len));

  // one extra slot: a head frame whose rest was fully released holds no block
  rfb_desc_q #(.QD(NUM_BLKS + 1)) u_desc_q (
    .clk(clk), .rst_n(rst_q), .push(push), .push_desc(push_desc), .pop(pop),
    .head(head), .empty(q_empty), .full(q_full));

  rfb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(store), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rp + rd_off), .rdata(rd_data));

  always_comb begin
    unit_rdy  = 1'b0;
    unit_done = 1'b0;
    unit_size = '0;
    unit_stat = '0;
    if (!q_empty) begin
      unit_rdy  = 1'b1;
      unit_done = 1'b1;
      unit_size = head.len - hd_off;
      unit_stat = {head.bad, head.stat};
    end else if ((cur_len - hd_off) >= RFB_LEN_W'(CHUNK)) begin
      unit_rdy  = 1'b1;
      unit_size = RFB_LEN_W'(CHUNK);
    end
    unit_blks = (unit_size + RFB_LEN_W'(BLK_BYTES - 1)) >> BOFF_W;
    load      = !irq && unit_rdy;
    rel       = irq && host_ack;
    pop       = rel && frame_end;
    hd_off_n  = rel ? (frame_end ? '0 : hd_off + RFB_LEN_W'(CHUNK)) : hd_off;
    rp_n      = rel ? rp + AW'({pres_blks, {BOFF_W{1'b0}}}) : rp;
    rd_off_n  = rel ? '0 : ((irq && rd_en) ? rd_off + 1'b1 : rd_off);
    blk_used_n = blk_used + BC_W'(alloc) - (rel ? pres_blks : '0);
    ovf_n     = ovf_evt | (ovf & !rel);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      irq        <= 1'b0;
      frame_cnt  <= '0;
      frame_end  <= 1'b0;
      frame_stat <= '0;
      pres_blks  <= '0;
    end else if (load || rel) begin
      irq        <= load;
      frame_cnt  <= load ? CNT_W'(unit_size) : '0;
      frame_end  <= load && unit_done;
      frame_stat <= load ? unit_stat : '0;
      pres_blks  <= load ? BC_W'(unit_blks) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hd_off   <= '0;
      rp       <= '0;
      rd_off   <= '0;
      blk_used <= '0;
      ovf      <= 1'b0;
    end else begin
      hd_off   <= hd_off_n;
      rp       <= rp_n;
      rd_off   <= rd_off_n;
      blk_used <= blk_used_n;
      ovf      <= ovf_n;
    end
  end

  // R6
  blk_bound_chk: assert property (@(posedge clk) disable iff (!rst_q)
    blk_used <= BC_W'(NUM_BLKS));
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (irq && !host_ack) |=> (irq && $stable(frame_cnt) && $stable(frame_end)));
  // R3
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (irq && !frame_end) |-> (frame_cnt == CNT_W'(CHUNK)));
  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!irq && host_ack) |=> $stable(rp));
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ovf_evt |=> ovf);
endmodule

// File: tb/rx_frame_buffer_bench.sv
module rx_frame_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, wr_last, rd_en, host_ack;
  logic [7:0] wr_data, rd_data;
  logic [2:0] wr_stat;
  logic       irq, frame_end, ovf;
  logic [6:0] frame_cnt;
  logic [3:0] frame_stat;

  always #5 clk = ~clk;

  rx_frame_buffer u_rx_frame_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .wr_stat(wr_stat), .rd_en(rd_en), .rd_data(rd_data), .host_ack(host_ack),
    .irq(irq), .frame_cnt(frame_cnt), .frame_end(frame_end),
    .frame_stat(frame_stat), .ovf(ovf));

  typedef struct { int cnt; bit done; int stat; } unit_t;
  unit_t      exp_u[$];
  logic [7:0] exp_b[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: sends bytes, records those expected to be stored
  task automatic put_bytes(int n, int seed, bit term, logic [2:0] st, int keep);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = 8'(seed + i);
      wr_last = term && (i == n - 1);
      wr_stat = st;
      if (i < keep) exp_b.push_back(8'(seed + i));
    end
    @(negedge clk);
    wr_en   = 1'b0;
    wr_last = 1'b0;
  endtask

  task automatic expect_unit(int c, bit d, int s);
    unit_t u;
    u.cnt = c; u.done = d; u.stat = s;
    exp_u.push_back(u);
  endtask

  // monitor: waits for a unit, compares it with the scoreboard, reads, acks
  task automatic service(string req);
    unit_t u;
    int    t = 0;
    while (!irq && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(irq == 1'b1, req, int'(irq), 1);
    if (exp_u.size() == 0) begin
      chk(1'b0, req, 1, 0);
      return;
    end
    u = exp_u.pop_front();
    chk(int'(frame_cnt) == u.cnt, req, int'(frame_cnt), u.cnt);
    chk(frame_end == u.done, req, int'(frame_end), int'(u.done));
    chk(int'(frame_stat) == u.stat, req, int'(frame_stat), u.stat);
    for (int i = 0; i < u.cnt; i++) begin
      logic [7:0] eb;
      @(negedge clk);
      eb = (exp_b.size() > 0) ? exp_b.pop_front() : 8'hxx;
      chk(rd_data === eb, req, int'(rd_data), int'(eb));
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en    = 1'b0;
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_last = 1'b0; wr_data = '0; wr_stat = '0;
    rd_en = 1'b0; host_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0 && frame_cnt == '0 && frame_end == 1'b0, "R1", int'(irq), 0);
    chk(frame_stat == '0 && ovf == 1'b0, "R1", int'(ovf), 0);

    // R2 single short frame
    put_bytes(5, 8'h10, 1'b1, 3'b101, 5);
    expect_unit(5, 1'b1, 4'b0101);
    service("R2");

    // R5 three frames queued before any service
    put_bytes(3, 8'h20, 1'b1, 3'b001, 3);
    put_bytes(10, 8'h30, 1'b1, 3'b010, 10);
    put_bytes(17, 8'h50, 1'b1, 3'b100, 17);
    expect_unit(3, 1'b1, 4'b0001);
    expect_unit(10, 1'b1, 4'b0010);
    expect_unit(17, 1'b1, 4'b0100);
    service("R5");
    service("R5");
    service("R5");

    // R9 ack with nothing presented, then a frame must read back intact
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R9", int'(irq), 0);
    put_bytes(4, 8'h70, 1'b1, 3'b111, 4);
    expect_unit(4, 1'b1, 4'b0111);
    service("R9");

    // R6 eight one-byte frames take all blocks; a ninth is dropped
    for (int f = 0; f < 8; f++) begin
      put_bytes(1, 8'h80 + f, 1'b1, 3'b001, 1);
      expect_unit(1, 1'b1, 4'b0001);
    end
    put_bytes(2, 8'hA0, 1'b1, 3'b010, 0);
    chk(ovf == 1'b1, "R6", int'(ovf), 1);
    for (int f = 0; f < 8; f++) service("R6");
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R6", int'(irq), 0);
    chk(ovf == 1'b0, "R7", int'(ovf), 0);

    // R8 freed blocks take 64 bytes of new frames without overflow
    for (int f = 0; f < 8; f++) begin
      put_bytes(8, 8'h08 * f, 1'b1, 3'b011, 8);
      expect_unit(8, 1'b1, 4'b0011);
    end
    chk(ovf == 1'b0, "R8", int'(ovf), 0);
    for (int f = 0; f < 8; f++) service("R8");

    // R3 / R4 long frame drained in slices
    put_bytes(40, 8'h01, 1'b0, 3'b000, 40);
    expect_unit(32, 1'b0, 0);
    service("R3");
    put_bytes(40, 8'h29, 1'b1, 3'b110, 40);
    expect_unit(32, 1'b0, 0);
    expect_unit(16, 1'b1, 4'b0110);
    service("R4");
    service("R4");

    // R7 overflow in mid-frame: 66 bytes sent, 64 kept, frame marked invalid
    put_bytes(66, 8'hC0, 1'b1, 3'b011, 64);
    chk(ovf == 1'b1, "R7", int'(ovf), 1);
    expect_unit(32, 1'b0, 0);
    expect_unit(32, 1'b1, 4'b1011);
    service("R7");
    service("R7");
    repeat (5) @(negedge clk);
    chk(ovf == 1'b0 && irq == 1'b0, "R7", int'(ovf), 0);
    chk(exp_u.size() == 0 && exp_b.size() == 0, "R5", exp_b.size(), 0);

    finish_run();
  end
endmodule